// File: doc/BRIEF.md
# Power Domain Sequencer Controller

This block controls a set of identical power domains through a small memory-mapped register port. Each domain has its own 128-byte register window. Software writes a command to switch a domain on or off. A hardware sequence engine then drives the domain's four control outputs in a fixed order: reset, clock enable, output isolation and power switch. Programmable waits, counted in controller clock cycles, sit between the steps.

Each domain's status word reports three things: whether a sequence is in flight, whether the last request has finished, and the domain's current on/off state. The completion flag stays set until software clears it by writing a one to it. The register port is a single-cycle write strobe with a combinational read path. Reads and writes aimed at offsets that carry no register, or at domain slots above the instantiated count, have no effect and return zero.

Top module: `pds_ctrl`

## Requirements
- R1: Domain n owns addresses n*0x80 to n*0x80+0x7F, selected by the address bits above bit 6. Offsets with no register, and domain slots at or above NUM_DOM, read as zero and ignore writes.
- R2: After reset, every domain is on. Reset is released (pd_rst_n=1), the clock is enabled, isolation is off and the switch is closed. Status reads 0x0001_0000 and all three delay registers read 4.
- R3: Writing 1 to the command register (offset 0x20) requests power-on, and writing 2 requests power-off. Any other value is ignored: no busy, no completion, no state change.
- R4: Power-off with off-delay D runs as follows, with k counting falling edges after the write edge. Isolation rises at k=2, the clock stops at k=3, reset asserts at k=4 and the switch opens at k=5+D. Busy is high for k=1..4+D.
- R5: Power-on with switch-delay S and on-delay N runs as follows. The switch closes at k=2, reset releases at k=3+S, the clock starts at k=4+S and isolation drops at k=5+S+N. Busy is high for k=1..4+S+N.
- R6: The status register (offset 0x24) holds busy in bit 3, completion in bit 1, and the state in bits 17:16 (1 = on, 2 = off). The state field changes only when a sequence finishes.
- R7: Completion sets when a transition finishes. A status write with bit 1 set clears it, and a write with bit 1 clear leaves it set.
- R8: A command written while busy is ignored. The running sequence finishes in its own direction.
- R9: A command equal to the current state sets completion on the next cycle, without busy and without any output change.
- R10: The switch delay (0x14), off delay (0x18) and on delay (0x1C) are 16-bit read/write fields. A value of 0 gives a one-cycle wait step.
- R11: The read-only views are ignored on write. 0x30 reports bit0 = reset released, bit1 = clock enabled and bit2 = isolation active. 0x34 bit0 reports switch closed. 0x00, 0x04, 0x08 and 0x0C mirror the reset-released, clock, isolation and switch-closed bits in bit 0, and 0x10 bit0 reports switch open.
- R12: Isolation is active whenever the clock is stopped. The clock is stopped whenever reset is asserted. Reset is asserted whenever the switch is open. At most one control output changes per cycle.
- R13: A sequence in one domain leaves every other domain's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: domain slot above bit 6, offset below |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pd_rst_n | output | NUM_DOM | Per-domain reset, low = asserted |
| pd_clk_en | output | NUM_DOM | Per-domain clock enable |
| pd_iso | output | NUM_DOM | Per-domain output isolation enable |
| pd_psw_on | output | NUM_DOM | Per-domain power switch, high = closed |

## Verification
The checker watches the four control outputs of every domain on every cycle. It checks the nesting of isolation, clock, reset and switch, confirms that no two of them move in the same cycle, and checks the all-on state after reset. These properties hold in either direction whatever the programmed delays are. The exact step timing for each delay value can only be shown by the bench's scenarios, which compare each domain against a cycle-indexed expectation. The same holds for the busy, completion and state fields, the dropping of commands that arrive while busy or with an invalid code, and the zero reads of unmapped offsets.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int DATA_W   = 32;
    localparam int WIN_BITS = 7;                 // 0x80-byte window per domain
    localparam int DLY_W    = 16;
    localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(4);

    // register offsets inside a window
    localparam logic [WIN_BITS-1:0] OFS_RSTV  = 7'h00;
    localparam logic [WIN_BITS-1:0] OFS_CLKV  = 7'h04;
    localparam logic [WIN_BITS-1:0] OFS_ISOV  = 7'h08;
    localparam logic [WIN_BITS-1:0] OFS_SWONV = 7'h0C;
    localparam logic [WIN_BITS-1:0] OFS_SWOFV = 7'h10;
    localparam logic [WIN_BITS-1:0] OFS_SWDLY = 7'h14;
    localparam logic [WIN_BITS-1:0] OFS_OFDLY = 7'h18;
    localparam logic [WIN_BITS-1:0] OFS_ONDLY = 7'h1C;
    localparam logic [WIN_BITS-1:0] OFS_CMD   = 7'h20;
    localparam logic [WIN_BITS-1:0] OFS_STAT  = 7'h24;
    localparam logic [WIN_BITS-1:0] OFS_GATE  = 7'h30;
    localparam logic [WIN_BITS-1:0] OFS_SWST  = 7'h34;

    localparam int BIT_DONE = 1;
    localparam int BIT_BUSY = 3;
    localparam int ST_LSB   = 16;

    localparam logic [1:0] ST_ON  = 2'd1;
    localparam logic [1:0] ST_OFF = 2'd2;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ISO_SET,
        PH_CLK_STOP,
        PH_RST_SET,
        PH_OFF_WAIT,
        PH_SW_CLOSE,
        PH_SW_WAIT,
        PH_CLK_RUN,
        PH_ON_WAIT
    } pd_phase_e;

    typedef struct packed {
        logic rst_n;
        logic clk_en;
        logic iso;
        logic psw_on;
    } pd_ctl_t;

    typedef struct packed {
        logic [DLY_W-1:0] sw;
        logic [DLY_W-1:0] off;
        logic [DLY_W-1:0] on;
    } pd_dly_t;

    function automatic pd_ctl_t ctl_powered();
        pd_ctl_t c;
        c.rst_n  = 1'b1;
        c.clk_en = 1'b1;
        c.iso    = 1'b0;
        c.psw_on = 1'b1;
        return c;
    endfunction

    function automatic logic cmd_code_ok(input logic [DATA_W-1:0] v);
        return (v == DATA_W'(ST_ON)) || (v == DATA_W'(ST_OFF));
    endfunction
endpackage

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_vld,
    input  logic [1:0] cmd_code,
    input  logic       clr_done,
    input  pd_dly_t    dly,
    output pd_ctl_t    ctl,
    output logic       busy,
    output logic       done,
    output logic [1:0] state
);
    pd_phase_e        ph;
    logic [DLY_W-1:0] cnt;

    assign busy = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            ctl   <= ctl_powered();
            done  <= 1'b0;
            state <= ST_ON;
        end else begin
            if (clr_done) done <= 1'b0;
            case (ph)
                PH_IDLE: if (cmd_vld) begin
                    if (cmd_code == state)       done <= 1'b1;
                    else if (cmd_code == ST_OFF) ph   <= PH_ISO_SET;
                    else                         ph   <= PH_SW_CLOSE;
                end
                // power-off: isolate, stop clock, assert reset, wait, open switch
                PH_ISO_SET:  begin ctl.iso    <= 1'b1; ph <= PH_CLK_STOP; end
                PH_CLK_STOP: begin ctl.clk_en <= 1'b0; ph <= PH_RST_SET;  end
                PH_RST_SET:  begin
                    ctl.rst_n <= 1'b0;
                    cnt       <= dly.off;
                    ph        <= PH_OFF_WAIT;
                end
                PH_OFF_WAIT: begin
                    if (cnt == '0) begin
                        ctl.psw_on <= 1'b0;
                        state      <= ST_OFF;
                        done       <= 1'b1;
                        ph         <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                // power-on: close switch, wait, release reset, run clock, wait, de-isolate
                PH_SW_CLOSE: begin
                    ctl.psw_on <= 1'b1;
                    cnt        <= dly.sw;
                    ph         <= PH_SW_WAIT;
                end
                PH_SW_WAIT: begin
                    if (cnt == '0) begin
                        ctl.rst_n <= 1'b1;
                        ph        <= PH_CLK_RUN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CLK_RUN: begin
                    ctl.clk_en <= 1'b1;
                    cnt        <= dly.on;
                    ph         <= PH_ON_WAIT;
                end
                PH_ON_WAIT: begin
                    if (cnt == '0) begin
                        ctl.iso <= 1'b0;
                        state   <= ST_ON;
                        done    <= 1'b1;
                        ph      <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [DATA_W-1:0]   wdata,
    input  pd_ctl_t             ctl,
    input  logic                busy,
    input  logic                done,
    input  logic [1:0]          state,
    output pd_dly_t             dly,
    output logic                cmd_vld,
    output logic [1:0]          cmd_code,
    output logic                clr_done,
    output logic [DATA_W-1:0]   rdata
);
    assign cmd_vld  = wr_en && (ofs == OFS_CMD) && cmd_code_ok(wdata);
    assign cmd_code = wdata[1:0];
    assign clr_done = wr_en && (ofs == OFS_STAT) && wdata[BIT_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            dly.sw  <= DLY_RST;
            dly.off <= DLY_RST;
            dly.on  <= DLY_RST;
        end else if (wr_en) begin
            if (ofs == OFS_SWDLY) dly.sw  <= wdata[DLY_W-1:0];
            if (ofs == OFS_OFDLY) dly.off <= wdata[DLY_W-1:0];
            if (ofs == OFS_ONDLY) dly.on  <= wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_RSTV:  rdata[0] = ctl.rst_n;
            OFS_CLKV:  rdata[0] = ctl.clk_en;
            OFS_ISOV:  rdata[0] = ctl.iso;
            OFS_SWONV: rdata[0] = ctl.psw_on;
            OFS_SWOFV: rdata[0] = ~ctl.psw_on;
            OFS_SWDLY: rdata[DLY_W-1:0] = dly.sw;
            OFS_OFDLY: rdata[DLY_W-1:0] = dly.off;
            OFS_ONDLY: rdata[DLY_W-1:0] = dly.on;
            OFS_STAT: begin
                rdata[BIT_DONE]      = done;
                rdata[BIT_BUSY]      = busy;
                rdata[ST_LSB +: 2]   = state;
            end
            OFS_GATE:  rdata[2:0] = {ctl.iso, ctl.clk_en, ctl.rst_n};
            OFS_SWST:  rdata[0]   = ctl.psw_on;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    parameter int ADDR_W  = DOM_W + WIN_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_DOM-1:0] pd_rst_n,
    output logic [NUM_DOM-1:0] pd_clk_en,
    output logic [NUM_DOM-1:0] pd_iso,
    output logic [NUM_DOM-1:0] pd_psw_on
);
    logic [DOM_W-1:0]    dom_idx;
    logic [WIN_BITS-1:0] ofs;
    logic [DATA_W-1:0]   rd_arr [NUM_DOM];

    assign dom_idx = reg_addr[ADDR_W-1:WIN_BITS];
    assign ofs     = reg_addr[WIN_BITS-1:0];

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pd_ctl_t    ctl;
        pd_dly_t    dly;
        logic       sel, busy, done, cmd_vld, clr_done;
        logic [1:0] state, cmd_code;

        assign sel = reg_wr && (dom_idx == DOM_W'(d));

        pds_regs u_regs (
            .clk(clk), .rst(rst), .wr_en(sel), .ofs(ofs), .wdata(reg_wdata),
            .ctl(ctl), .busy(busy), .done(done), .state(state),
            .dly(dly), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
            .clr_done(clr_done), .rdata(rd_arr[d])
        );

        pds_seq u_seq (
            .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
            .clr_done(clr_done), .dly(dly), .ctl(ctl),
            .busy(busy), .done(done), .state(state)
        );

        assign pd_rst_n[d]  = ctl.rst_n;
        assign pd_clk_en[d] = ctl.clk_en;
        assign pd_iso[d]    = ctl.iso;
        assign pd_psw_on[d] = ctl.psw_on;
    end

    always_comb begin
        reg_rdata = '0;
        for (int d = 0; d < NUM_DOM; d++)
            if (dom_idx == DOM_W'(d)) reg_rdata = rd_arr[d];
    end
endmodule

// File: rtl/pds_ctrl_chk.sv
module pds_ctrl_chk #(
    parameter int NUM_DOM = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DOM-1:0] pd_rst_n,
    input logic [NUM_DOM-1:0] pd_clk_en,
    input logic [NUM_DOM-1:0] pd_iso,
    input logic [NUM_DOM-1:0] pd_psw_on
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
        assert_iso_when_gated_R12: assert property (@(posedge clk) disable iff (rst)
            !pd_clk_en[d] |-> pd_iso[d]);

        assert_gated_when_reset_R12: assert property (@(posedge clk) disable iff (rst)
            !pd_rst_n[d] |-> !pd_clk_en[d]);

        assert_reset_when_open_R12: assert property (@(posedge clk) disable iff (rst)
            !pd_psw_on[d] |-> !pd_rst_n[d]);

        assert_single_step_R12: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ($countones({pd_rst_n[d], pd_clk_en[d], pd_iso[d], pd_psw_on[d]} ^
                             $past({pd_rst_n[d], pd_clk_en[d], pd_iso[d], pd_psw_on[d]})) <= 1));

        assert_reset_on_R2: assert property (@(posedge clk)
            rst |=> (pd_rst_n[d] && pd_clk_en[d] && !pd_iso[d] && pd_psw_on[d]));
    end
endmodule

bind pds_ctrl pds_ctrl_chk #(.NUM_DOM(NUM_DOM)) u_chk (
    .clk(clk), .rst(rst), .pd_rst_n(pd_rst_n), .pd_clk_en(pd_clk_en),
    .pd_iso(pd_iso), .pd_psw_on(pd_psw_on)
);

// File: tb/pds_ctrl_tb_top.sv
module pds_ctrl_tb_top;
    localparam int ND = 3;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [ND-1:0] pd_rst_n, pd_clk_en, pd_iso, pd_psw_on;

    int n_vec = 0;
    int n_bad = 0;
    bit is_on [ND];
    int m_sw [ND], m_off [ND], m_on [ND];

    always #4 clk = ~clk;

    pds_ctrl #(.NUM_DOM(ND)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_rst_n(pd_rst_n),
        .pd_clk_en(pd_clk_en), .pd_iso(pd_iso), .pd_psw_on(pd_psw_on)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] adr(input int dom, input logic [6:0] o);
        return AW'(dom * 128) + AW'(o);
    endfunction

    function automatic logic [3:0] ctl_of(input int d);
        return {pd_rst_n[d], pd_clk_en[d], pd_iso[d], pd_psw_on[d]};
    endfunction

    // expected {rst_n, clk_en, iso, psw_on} k falling edges after the command edge
    function automatic logic [3:0] exp_ctl(input bit to_off, input int k,
                                          input int s, input int dof, input int n);
        if (to_off) return {k < 4, k < 3, k >= 2, k < 5 + dof};
        return {k >= 3 + s, k >= 4 + s, k < 5 + s + n, k >= 2};
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_delays(input int dom, input int s, input int dof, input int n);
        wr(adr(dom, 7'h14), 32'(s));
        wr(adr(dom, 7'h18), 32'(dof));
        wr(adr(dom, 7'h1C), 32'(n));
        m_sw[dom] = s; m_off[dom] = dof; m_on[dom] = n;
    endtask

    // toggles a domain and checks every cycle of the sequence
    task automatic run_cmd(input int dom, input string req);
        logic [31:0] st, v;
        logic [3:0]  snap [ND];
        bit          to_off = is_on[dom];
        int          len = to_off ? 4 + m_off[dom] : 4 + m_sw[dom] + m_on[dom];
        for (int d = 0; d < ND; d++) snap[d] = ctl_of(d);
        wr(adr(dom, 7'h20), to_off ? 32'd2 : 32'd1);
        for (int k = 1; k <= len + 1; k++) begin
            rd(adr(dom, 7'h24), st);
            check({st[3], ctl_of(dom)} == {k <= len, exp_ctl(to_off, k, m_sw[dom], m_off[dom], m_on[dom])},
                  req, $sformatf("dom%0d step k=%0d {busy,ctl}", dom, k),
                  32'({st[3], ctl_of(dom)}),
                  32'({k <= len, exp_ctl(to_off, k, m_sw[dom], m_off[dom], m_on[dom])}));
            for (int d = 0; d < ND; d++)
                if (d != dom)
                    check(ctl_of(d) == snap[d], "R13", $sformatf("bystander dom%0d", d),
                          32'(ctl_of(d)), 32'(snap[d]));
            @(negedge clk);
        end
        is_on[dom] = !to_off;
        rd(adr(dom, 7'h24), st);
        check(st == (is_on[dom] ? 32'h0001_0002 : 32'h0002_0002), "R6",
              "status after sequence", st, is_on[dom] ? 32'h0001_0002 : 32'h0002_0002);
        rd(adr(dom, 7'h30), v);
        check(v == (is_on[dom] ? 32'h3 : 32'h4), "R11", "gate status", v,
              is_on[dom] ? 32'h3 : 32'h4);
        rd(adr(dom, 7'h34), v);
        check(v == 32'(is_on[dom]), "R11", "switch status", v, 32'(is_on[dom]));
        rd(adr(dom, 7'h10), v);
        check(v == 32'(!is_on[dom]), "R11", "switch-open view", v, 32'(!is_on[dom]));
        wr(adr(dom, 7'h24), 32'h0);
        rd(adr(dom, 7'h24), st);
        check(st[1] == 1'b1, "R7", "done kept by write without bit1", 32'(st[1]), 32'd1);
        wr(adr(dom, 7'h24), st);
        rd(adr(dom, 7'h24), st);
        check(st[1] == 1'b0, "R7", "done cleared by W1C", 32'(st[1]), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int d = 0; d < ND; d++) begin
            is_on[d] = 1'b1; m_sw[d] = 4; m_off[d] = 4; m_on[d] = 4;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        for (int d = 0; d < ND; d++) begin
            check(ctl_of(d) == 4'b1101, "R2", $sformatf("dom%0d outputs", d), 32'(ctl_of(d)), 32'hD);
            rd(adr(d, 7'h24), v);
            check(v == 32'h0001_0000, "R2", "status", v, 32'h0001_0000);
            rd(adr(d, 7'h18), v);
            check(v == 32'd4, "R2", "off delay default", v, 32'd4);
        end
        rd(adr(0, 7'h30), v);
        check(v == 32'h3, "R11", "gate status after reset", v, 32'h3);

        // R10 readback and zero delays, R4/R5 directed
        set_delays(1, 0, 0, 0);
        rd(adr(1, 7'h14), v);
        check(v == 32'd0, "R10", "switch delay readback", v, 32'd0);
        run_cmd(1, "R4");
        run_cmd(1, "R5");
        set_delays(0, 3, 9, 7);
        rd(adr(0, 7'h1C), v);
        check(v == 32'd7, "R10", "on delay readback", v, 32'd7);
        run_cmd(0, "R4");
        run_cmd(0, "R5");

        // R9 same-state command
        wr(adr(2, 7'h20), 32'd1);
        rd(adr(2, 7'h24), v);
        check(v == 32'h0001_0002, "R9", "same-state completes at once", v, 32'h0001_0002);
        check(ctl_of(2) == 4'b1101, "R9", "outputs untouched", 32'(ctl_of(2)), 32'hD);
        wr(adr(2, 7'h24), 32'h2);

        // R3 invalid command code
        wr(adr(2, 7'h20), 32'd3);
        rd(adr(2, 7'h24), v);
        check(v == 32'h0001_0000, "R3", "code 3 ignored", v, 32'h0001_0000);
        wr(adr(2, 7'h20), 32'h101);
        rd(adr(2, 7'h24), v);
        check(v == 32'h0001_0000, "R3", "code 0x101 ignored", v, 32'h0001_0000);

        // R8 command while busy
        set_delays(0, 1, 8, 1);
        wr(adr(0, 7'h20), 32'd2);
        wr(adr(0, 7'h20), 32'd1);
        for (int i = 0; i < 40; i++) begin
            rd(adr(0, 7'h24), v);
            if (!v[3]) break;
            @(negedge clk);
        end
        check(v == 32'h0002_0002, "R8", "busy command dropped, state off", v, 32'h0002_0002);
        check(ctl_of(0) == 4'b0010, "R8", "outputs off", 32'(ctl_of(0)), 32'h2);
        wr(adr(0, 7'h24), 32'h2);
        is_on[0] = 1'b0;
        run_cmd(0, "R5");

        // R1 unmapped offsets and domain slot
        rd(adr(0, 7'h28), v);
        check(v == 32'd0, "R1", "offset 0x28 reads zero", v, 32'd0);
        wr(adr(0, 7'h40), 32'hFFFF_FFFF);
        rd(adr(0, 7'h40), v);
        check(v == 32'd0, "R1", "offset 0x40 write ignored", v, 32'd0);
        wr(adr(3, 7'h18), 32'h55);
        rd(adr(3, 7'h18), v);
        check(v == 32'd0, "R1", "slot 3 reads zero", v, 32'd0);
        for (int d = 0; d < ND; d++) begin
            rd(adr(d, 7'h18), v);
            check(v == 32'(m_off[d]), "R1", $sformatf("dom%0d off delay unchanged", d),
                  v, 32'(m_off[d]));
        end
        wr(adr(1, 7'h30), 32'h0);
        rd(adr(1, 7'h30), v);
        check(v == 32'h3, "R11", "gate status write ignored", v, 32'h3);

        // random toggles across domains
        for (int i = 0; i < 16; i++) begin
            int dom = int'($urandom_range(ND - 1, 0));
            set_delays(dom, int'($urandom_range(5, 0)), int'($urandom_range(5, 0)),
                       int'($urandom_range(5, 0)));
            run_cmd(dom, is_on[dom] ? "R4" : "R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule